// File: doc/BRIEF.md
# Byte-Wide Configuration Image Loader

This block loads a configuration image into a programmable target device through the target's slave byte-parallel configuration port. The image arrives as a byte stream with valid/ready flow control. When `start` is seen, the loader pulls the program-request line low for a fixed number of cycles. It then releases that line and waits for the target to let its open-drain init line float high. The write phase follows: chip-select is low, the direction line selects write, and every accepted payload byte is driven onto the port together with a one-cycle write strobe.

The first `hdr_len` bytes of the stream are container header bytes. The loader takes them from the stream but never drives them to the port. When `bit_rev` is high, the loader mirrors the bit order of each payload byte. After the byte flagged as last, the loader issues a fixed number of extra strobe cycles with chip-select released, so the target's start-up sequence can finish. It then waits for the target's done line. The load ends in one of two sticky states: done, or error with a cause code. A new `start` clears either state and begins a fresh load.

The target's init and done lines are asynchronous to the loader clock. Each passes through a synchronizer of `SYNC_STAGES` flops before any decision uses it.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is held and after it is released, `cfg_prog_n`, `cfg_cs_n` and `cfg_rdwr_n` are 1, `cfg_wr` and `s_ready` are 0, `cfg_d` is 0, and `load_done`, `load_err` and `err_code` are 0.
- R2: A `start` sampled while idle, done or failed drives `cfg_prog_n` low for exactly `PROG_CYCLES` cycles, starting in the cycle after the sampling edge.
- R3: After `cfg_prog_n` rises, the write phase begins only once the synchronized `cfg_init_n` reads high. It begins on the edge after the synchronizer output goes high.
- R4: `s_ready` is high only in the write phase while the synchronized init is high. `cfg_rdwr_n` is 0 (write) from the start of the write phase until the done wait ends, and 1 at all other times.
- R5: The first `hdr_len` bytes accepted from the stream produce no write strobe.
- R6: Each accepted payload byte appears on `cfg_d` for exactly one cycle, with `cfg_wr` high and `cfg_cs_n` low, in the cycle after its handshake. Bytes appear in stream order.
- R7: With `bit_rev` = 1, bit i of the port byte equals bit 7-i of the stream byte. With `bit_rev` = 0 the byte passes unchanged.
- R8: After the handshake of the byte with `s_last` = 1, exactly `TAIL_CLKS` cycles follow with `cfg_wr` high and `cfg_cs_n` high.
- R9: After the tail cycles, `load_done` rises on the edge after the synchronized `cfg_done` reads high. It stays high until the next `start`. `load_done` and `load_err` are never high together.
- R10: If the synchronized init stays low for `INIT_TIMEOUT` cycles of the wait phase, `load_err` rises with `err_code` = 1.
- R11: If the synchronized init reads low during the write phase, the loader stops: `s_ready` drops, no further strobes are issued, and `load_err` rises with `err_code` = 2.
- R12: If the synchronized done stays low for `DONE_TIMEOUT` cycles after the tail, `load_err` rises with `err_code` = 3.
- R13: A new `start` clears `load_done`, `load_err` and `err_code` in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loader clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (sampled when idle, done or failed) |
| hdr_len | input | HDR_W | Number of leading stream bytes to discard |
| bit_rev | input | 1 | Mirror the bit order of each payload byte |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Loader accepts a stream byte |
| cfg_prog_n | output | 1 | Program request to target, active low |
| cfg_init_n | input | 1 | Target init line, active low, asynchronous |
| cfg_done | input | 1 | Target configuration-done line, asynchronous |
| cfg_cs_n | output | 1 | Chip-select to target, active low |
| cfg_rdwr_n | output | 1 | Direction: 0 = write |
| cfg_wr | output | 1 | Write strobe, one cycle per byte or tail cycle |
| cfg_d | output | 8 | Configuration data byte |
| load_done | output | 1 | Load finished successfully (sticky) |
| load_err | output | 1 | Load failed (sticky) |
| err_code | output | 2 | Failure cause: 1 init timeout, 2 init lost while writing, 3 done timeout |

## Verification
The hardest case to reach is the loss of init in the middle of the write phase. Bytes are still in flight through the synchronizer delay when this happens, so the bench must stop at the exact cycle the synchronized line is seen low. The emulated target in the bench counts payload strobes and pulls init low after a chosen count. The cycle model then predicts how many more strobes are legal before the fault. The two timeouts are reached by a target that never releases init, and by one that never raises done. A normal load after a failure shows that the sticky flags clear.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_WRITE,
        ST_TAIL,
        ST_WAIT_DONE,
        ST_DONE,
        ST_FAULT
    } ld_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_INIT_TMO  = 2'd1,
        FLT_INIT_LOST = 2'd2,
        FLT_DONE_TMO  = 2'd3
    } fault_e;

    // Registered drive of the target's data port.
    typedef struct packed {
        logic              cs_n;
        logic              stb;
        logic [BYTE_W-1:0] d;
    } port_drv_t;

    function automatic int larger(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d};
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfgl_byte_prep.sv
module cfgl_byte_prep
    import cfgl_pkg::*;
#(
    parameter int HDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic              rev_en,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              is_payload,
    output logic [BYTE_W-1:0] out_byte
);
    logic [HDR_W-1:0] skipped;

    assign is_payload = (skipped >= hdr_len);
    assign out_byte   = rev_en ? mirror_byte(in_byte) : in_byte;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            skipped <= '0;
        end else if (take && !is_payload) begin
            skipped <= skipped + 1'b1;
        end
    end
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int PROG_CYCLES  = 64,
    parameter int INIT_TIMEOUT = 100000,
    parameter int TAIL_CLKS    = 16,
    parameter int DONE_TIMEOUT = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              init_ok,
    input  logic              done_ok,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              is_payload,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              take,
    output logic              clear_hdr,
    output logic              s_ready,
    output logic              prog_n,
    output logic              rdwr_n,
    output port_drv_t         drv,
    output logic              done_o,
    output fault_e            fault_o
);
    localparam int CNT_MAX = larger(larger(PROG_CYCLES, INIT_TIMEOUT),
                                    larger(TAIL_CLKS, DONE_TIMEOUT));
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_TIMEOUT - 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CLKS - 1);
    localparam logic [CW-1:0] DONE_LAST = CW'(DONE_TIMEOUT - 1);

    ld_state_e      state;
    logic [CW-1:0]  cnt;
    logic           restart;

    assign restart   = start && (state == ST_IDLE || state == ST_DONE || state == ST_FAULT);
    assign clear_hdr = restart;
    assign s_ready   = (state == ST_WRITE) && init_ok;
    assign take      = s_ready && s_valid;
    assign prog_n    = (state != ST_PROG);
    assign rdwr_n    = !(state == ST_WRITE || state == ST_TAIL || state == ST_WAIT_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            drv     <= '{cs_n: 1'b1, stb: 1'b0, d: '0};
            done_o  <= 1'b0;
            fault_o <= FLT_NONE;
        end else begin
            drv.stb  <= 1'b0;
            drv.cs_n <= 1'b1;
            case (state)
                ST_IDLE, ST_DONE, ST_FAULT: begin
                    if (restart) begin
                        state   <= ST_PROG;
                        cnt     <= '0;
                        done_o  <= 1'b0;
                        fault_o <= FLT_NONE;
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state <= ST_WAIT_INIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_INIT: begin
                    if (init_ok) begin
                        state <= ST_WRITE;
                        cnt   <= '0;
                    end else if (cnt == INIT_LAST) begin
                        state   <= ST_FAULT;
                        fault_o <= FLT_INIT_TMO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (!init_ok) begin
                        state   <= ST_FAULT;
                        fault_o <= FLT_INIT_LOST;
                    end else begin
                        drv.cs_n <= 1'b0;
                        if (take) begin
                            if (is_payload) begin
                                drv.stb <= 1'b1;
                                drv.d   <= byte_in;
                            end
                            if (s_last) begin
                                state <= ST_TAIL;
                                cnt   <= '0;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    drv.stb <= 1'b1;
                    if (cnt == TAIL_LAST) begin
                        state <= ST_WAIT_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_DONE: begin
                    if (done_ok) begin
                        state  <= ST_DONE;
                        done_o <= 1'b1;
                    end else if (cnt == DONE_LAST) begin
                        state   <= ST_FAULT;
                        fault_o <= FLT_DONE_TMO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfgl_pkg::*;
#(
    parameter int PROG_CYCLES  = 64,
    parameter int INIT_TIMEOUT = 100000,
    parameter int TAIL_CLKS    = 16,
    parameter int DONE_TIMEOUT = 100000,
    parameter int SYNC_STAGES  = 2,
    parameter int HDR_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic              bit_rev,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              cfg_prog_n,
    input  logic              cfg_init_n,
    input  logic              cfg_done,
    output logic              cfg_cs_n,
    output logic              cfg_rdwr_n,
    output logic              cfg_wr,
    output logic [BYTE_W-1:0] cfg_d,
    output logic              load_done,
    output logic              load_err,
    output logic [1:0]        err_code
);
    logic              init_ok;
    logic              done_ok;
    logic              take;
    logic              clear_hdr;
    logic              is_payload;
    logic [BYTE_W-1:0] prepped;
    port_drv_t         drv;
    fault_e            fault;

    cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
        .clk(clk), .rst(rst), .d(cfg_init_n), .q(init_ok)
    );

    cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk(clk), .rst(rst), .d(cfg_done), .q(done_ok)
    );

    cfgl_byte_prep #(.HDR_W(HDR_W)) u_prep (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear_hdr),
        .take       (take),
        .hdr_len    (hdr_len),
        .rev_en     (bit_rev),
        .in_byte    (s_data),
        .is_payload (is_payload),
        .out_byte   (prepped)
    );

    cfgl_seq #(
        .PROG_CYCLES  (PROG_CYCLES),
        .INIT_TIMEOUT (INIT_TIMEOUT),
        .TAIL_CLKS    (TAIL_CLKS),
        .DONE_TIMEOUT (DONE_TIMEOUT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .init_ok    (init_ok),
        .done_ok    (done_ok),
        .s_valid    (s_valid),
        .s_last     (s_last),
        .is_payload (is_payload),
        .byte_in    (prepped),
        .take       (take),
        .clear_hdr  (clear_hdr),
        .s_ready    (s_ready),
        .prog_n     (cfg_prog_n),
        .rdwr_n     (cfg_rdwr_n),
        .drv        (drv),
        .done_o     (load_done),
        .fault_o    (fault)
    );

    assign cfg_cs_n = drv.cs_n;
    assign cfg_wr   = drv.stb;
    assign cfg_d    = drv.d;
    assign err_code = fault;
    assign load_err = (fault != FLT_NONE);
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst,
    input logic s_valid,
    input logic s_ready,
    input logic cfg_prog_n,
    input logic cfg_cs_n,
    input logic cfg_rdwr_n,
    input logic cfg_wr,
    input logic load_done,
    input logic load_err
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst)              low_run <= 0;
        else if (!cfg_prog_n) low_run <= low_run + 1;
        else                  low_run <= 0;
    end

    // R2: program request never stays low longer than the configured width
    p_prog_not_long_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_n |-> (low_run < PROG_CYCLES));

    // R2: when program request rises, the full width has elapsed
    p_prog_full_width_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_prog_n && low_run != 0) |-> (low_run == PROG_CYCLES));

    // R4: the stream is only accepted in the write phase
    p_ready_in_write_r4: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (cfg_prog_n && !cfg_rdwr_n && !load_err && !load_done));

    // R6: a chip-selected strobe always follows a stream handshake
    p_strobe_after_take_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_cs_n) |-> $past(s_valid && s_ready));

    // R4: every strobe is issued with write direction
    p_strobe_write_dir_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> !cfg_rdwr_n);

    // R11: a failed load is silent on the port and on the stream
    p_fault_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        load_err |-> (!cfg_wr && !s_ready));

    // R9: done and error are exclusive
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(load_done && load_err));
endmodule

bind cfg_byte_loader cfgl_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .cfg_prog_n (cfg_prog_n),
    .cfg_cs_n   (cfg_cs_n),
    .cfg_rdwr_n (cfg_rdwr_n),
    .cfg_wr     (cfg_wr),
    .load_done  (load_done),
    .load_err   (load_err)
);

// File: tb/tb_cfg_byte_loader.sv
`timescale 1ns/1ps
module tb_cfg_byte_loader;
    localparam int P  = 8;
    localparam int IT = 40;
    localparam int T  = 6;
    localparam int DT = 50;
    localparam int S  = 2;
    localparam int HW = 16;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [HW-1:0] hdr_len = '0;
    logic bit_rev = 0;
    logic s_valid = 0;
    logic [7:0] s_data = '0;
    logic s_last = 0;
    logic s_ready;
    logic cfg_prog_n;
    logic cfg_init_n = 1;
    logic cfg_done = 0;
    logic cfg_cs_n, cfg_rdwr_n, cfg_wr;
    logic [7:0] cfg_d;
    logic load_done, load_err;
    logic [1:0] err_code;

    always #2.5 clk = ~clk;

    cfg_byte_loader #(
        .PROG_CYCLES(P), .INIT_TIMEOUT(IT), .TAIL_CLKS(T),
        .DONE_TIMEOUT(DT), .SYNC_STAGES(S), .HDR_W(HW)
    ) dut (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // ---------------- cycle reference model ----------------
    // phases: 0 idle 1 prog 2 wait-init 3 write 4 tail 5 wait-done 6 done 7 fault
    int m_ph = 0, m_cnt = 0, m_hdr = 0, m_code = 0;
    bit m_cs_n = 1, m_wr = 0, m_done = 0;
    logic [S-1:0] isync = '0, dsync = '0;

    always @(posedge clk) begin
        bit is, ds, rdy, hs;
        is  = isync[S-1];
        ds  = dsync[S-1];
        rdy = (m_ph == 3) && is;
        hs  = rdy && s_valid;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_hdr = 0; m_code = 0;
            m_cs_n = 1; m_wr = 0; m_done = 0;
            isync = '0; dsync = '0;
        end else begin
            m_wr = 0; m_cs_n = 1;
            if (m_ph == 0 || m_ph == 6 || m_ph == 7) begin
                if (start) begin m_ph = 1; m_cnt = 0; m_hdr = 0; m_done = 0; m_code = 0; end
            end else if (m_ph == 1) begin
                if (m_cnt == P - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 2) begin
                if (is) begin m_ph = 3; m_cnt = 0; end
                else if (m_cnt == IT - 1) begin m_ph = 7; m_code = 1; end
                else m_cnt++;
            end else if (m_ph == 3) begin
                if (!is) begin m_ph = 7; m_code = 2; end
                else begin
                    m_cs_n = 0;
                    if (hs) begin
                        if (m_hdr >= int'(hdr_len)) m_wr = 1; else m_hdr++;
                        if (s_last) begin m_ph = 4; m_cnt = 0; end
                    end
                end
            end else if (m_ph == 4) begin
                m_wr = 1;
                if (m_cnt == T - 1) begin m_ph = 5; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 5) begin
                if (ds) begin m_ph = 6; m_done = 1; end
                else if (m_cnt == DT - 1) begin m_ph = 7; m_code = 3; end
                else m_cnt++;
            end
            isync = {isync[S-2:0], cfg_init_n};
            dsync = {dsync[S-2:0], cfg_done};
        end
    end

    // ---------------- target emulation and per-clock compare ----------------
    logic [7:0] exp_q[$];
    int init_delay = 4;    // -1: never release init
    int drop_after = 0;    // >0: pull init low after this many payload strobes
    bit done_ok = 1;
    int init_wait = 0, pay_seen = 0, tail_seen = 0;
    bit dropped = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check("R2",  "prog_n",  cfg_prog_n, (m_ph != 1));
            check("R4",  "s_ready", s_ready, ((m_ph == 3) && isync[S-1]));
            check("R4",  "rdwr_n",  cfg_rdwr_n, !(m_ph == 3 || m_ph == 4 || m_ph == 5));
            check("R6",  "cs_n",    cfg_cs_n, m_cs_n);
            check("R8",  "wr",      cfg_wr, m_wr);
            check("R9",  "done",    load_done, m_done);
            check("R10", "err",     load_err, (m_code != 0));
            check("R12", "code",    err_code, m_code);
            if (cfg_wr && !cfg_cs_n) begin
                if (exp_q.size() == 0) begin
                    check("R5", "unexpected payload strobe", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R7", "payload byte", cfg_d, e);
                end
                pay_seen++;
            end
            if (cfg_wr && cfg_cs_n) tail_seen++;
        end
        // target side
        if (!cfg_prog_n) begin
            cfg_init_n = 0; cfg_done = 0;
            init_wait = 0; pay_seen = 0; tail_seen = 0; dropped = 0;
        end else begin
            if (!cfg_init_n && init_delay >= 0 && !dropped) begin
                init_wait++;
                if (init_wait >= init_delay) cfg_init_n = 1;
            end
            if (drop_after > 0 && pay_seen >= drop_after && !dropped) begin
                cfg_init_n = 0; dropped = 1;
            end
            if (done_ok && tail_seen == T) cfg_done = 1;
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] img[64];

    task automatic push_stream(input int n, input bit gaps);
        int idx = 0;
        int k = 0;
        while (idx < n) begin
            @(negedge clk);
            if (load_err) break;
            k++;
            if (gaps && (k % 3 == 1)) begin
                s_valid = 0; s_last = 0;
            end else begin
                s_valid = 1; s_data = img[idx]; s_last = (idx == n - 1);
                if (s_ready) idx++;
            end
        end
        @(negedge clk);
        s_valid = 0; s_last = 0;
    endtask

    task automatic run_load(input int hdr, input bit rev, input int n, input bit gaps,
                            input int idly, input int drop, input bit dok, input int exp_code);
        hdr_len = HW'(hdr); bit_rev = rev;
        init_delay = idly; drop_after = drop; done_ok = dok;
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            img[i] = 8'((i * 37 + 11 + hdr * 5) ^ (rev ? 8'hA5 : 8'h3C));
            if (i >= hdr) exp_q.push_back(rev ? flip8(img[i]) : img[i]);
        end
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check("R13", "done cleared by start", load_done, 0);
        check("R13", "err cleared by start",  load_err, 0);
        check("R2",  "prog_n low after start", cfg_prog_n, 0);
        push_stream(n, gaps);
        while (!load_done && !load_err) @(negedge clk);
        @(negedge clk);
        check((exp_code == 0) ? "R9" : (exp_code == 1) ? "R10" : (exp_code == 2) ? "R11" : "R12",
              "final code", err_code, exp_code);
        check("R9", "final done", load_done, (exp_code == 0));
        if (exp_code == 0) begin
            check("R6", "all payload bytes written", exp_q.size(), 0);
            check("R8", "tail strobes", tail_seen, T);
        end else if (exp_code == 1) begin
            check("R3", "no strobe without init", pay_seen, 0);
        end else if (exp_code == 2) begin
            check("R11", "stopped before end", (exp_q.size() > 0), 1);
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "prog_n in reset", cfg_prog_n, 1);
        check("R1", "cs_n in reset", cfg_cs_n, 1);
        check("R1", "wr in reset", cfg_wr, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        check("R1", "rdwr_n idle", cfg_rdwr_n, 1);
        check("R1", "ready idle", s_ready, 0);
        check("R1", "data idle", cfg_d, 0);
        check("R1", "done idle", load_done, 0);
        check("R1", "err idle", load_err, 0);
        // R5 R6: header skipped, plain order, continuous stream
        run_load(3, 0, 12, 0, 5, 0, 1, 0);
        // R7: mirrored bytes, no header, gaps in stream
        run_load(0, 1, 9, 1, 2, 0, 1, 0);
        // R10: init never released
        run_load(2, 0, 6, 0, -1, 0, 1, 1);
        // R13 then R11: init lost after two payload bytes
        run_load(1, 1, 20, 0, 3, 2, 1, 2);
        // R12: done never rises
        run_load(0, 0, 5, 0, 1, 0, 0, 3);
        // recovery: normal load after a failure, header covering most of image
        run_load(7, 0, 8, 1, 6, 0, 1, 0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule